// File: doc/BRIEF.md
# Byte-Fed Serial Frame Shifter with Boundary Latch

This block turns a stream of bytes into a clocked serial bit stream for a daisy chain of LED driver devices. Each driver holds one pixel frame of 31 bits. Bytes come in through a valid/ready handshake and go out most significant bit first on a data line, together with a serial clock made by dividing the system clock. The block counts every bit it shifts. When 31 bits have gone out, it pulses a latch line. This boundary usually falls partway through a byte.

Once a frame boundary is reached, shifting stops and the rest of the current byte stays in the block. In paced mode the latch fires on the next frame-rate tick, so the tick sets the scroll rate of the chain. In free-running mode the latch fires as soon as the boundary is reached. After the latch pulse ends, the bits left in the byte are shifted out first. The boundary moves forward one bit per frame relative to the bytes, and after eight frames (31 bytes) it lines up with a byte edge again.

Top module: `nonaligned_frame_serializer`

## Requirements
- R1: After a synchronous reset, `latch` and `ser_clk` are low, `ser_data` is 0 and `in_ready` is high. Any partly shifted byte is discarded, and the bit count restarts at zero.
- R2: A byte is accepted on a clock where `in_valid` and `in_ready` are both high. `in_ready` is high only when no accepted bit remains unshifted, `ser_clk` is low, no frame boundary is pending and `latch` is low.
- R3: Bits leave most significant bit first. For each bit, `ser_clk` is low for HALF_PERIOD system clocks and then high for HALF_PERIOD system clocks. `ser_data` changes only while `ser_clk` is low or on the clock where it falls, and it holds steady while `ser_clk` is high.
- R4: `latch` rises exactly when 31 rising edges of `ser_clk` have occurred since the previous latch or reset. Those 31 bits are the next 31 bits of the accepted byte stream, even when the boundary falls inside a byte.
- R5: No rising edge of `ser_clk` occurs after the 31st bit of a frame until the latch pulse for that frame has ended.
- R6: When `free_run` is low, `latch` rises on the clock after `rate_tick` is sampled high while a boundary is pending. A tick at any other time has no effect.
- R7: When `free_run` is high, `latch` rises HALF_PERIOD+1 system clocks after the 31st rising edge of `ser_clk`, whatever `rate_tick` does.
- R8: `latch` stays high for exactly LATCH_CYCLES system clocks. Shifting then resumes with the remaining bits of the interrupted byte.
- R9: After 31 bytes (eight frames) from reset, the eighth latch leaves no bits pending, and `in_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| free_run | input | 1 | 1: latch at each boundary without waiting for a tick |
| rate_tick | input | 1 | One-clock pulse that allows a pending latch |
| in_data | input | 8 | Byte to serialize |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Block can take a byte this clock |
| ser_clk | output | 1 | Serial shift clock to the driver chain |
| ser_data | output | 1 | Serial data, MSB first |
| latch | output | 1 | Frame latch pulse to the driver chain |

## Verification
The hardest condition to reach is a frame boundary in the middle of a byte that is then held for a long time with no tick, while leftover bits are still waiting in the block. The stimulus stops the tick generator, sends four bytes and waits hundreds of clocks to confirm that the serial clock stays quiet and no latch occurs. It then gives a single manual tick and checks that the one carried bit goes out. A full run of 31 bytes with a periodic tick takes the boundary offset through all eight positions. A free-running pass and a reset in the middle of a byte cover the remaining orderings.

// File: rtl/serializer_pkg.sv
package serializer_pkg;
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_HOLD  = 2'd1,
        ST_LATCH = 2'd2
    } fs_state_e;
endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
    parameter int HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic bit_done
);
    localparam int PER = 2 * HALF_PERIOD;
    localparam int PW  = (PER > 1) ? $clog2(PER) : 1;

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          sclk;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d        = q;
        bit_done = 1'b0;
        if (!run) begin
            d = '0;
        end else if (q.phase == PW'(PER - 1)) begin
            d.phase  = '0;
            d.sclk   = 1'b0;
            bit_done = 1'b1;
        end else begin
            d.phase = q.phase + PW'(1);
            d.sclk  = (q.phase >= PW'(HALF_PERIOD - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sclk = q.sclk;
endmodule

// File: rtl/frame_bit_counter.sv
module frame_bit_counter #(
    parameter int FRAME_BITS = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic wrap
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (inc) begin
            if (cnt_q == CW'(FRAME_BITS - 1)) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/latch_pulse_gen.sv
module latch_pulse_gen #(
    parameter int LATCH_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int LW = (LATCH_CYCLES > 1) ? $clog2(LATCH_CYCLES) : 1;

    typedef struct packed {
        logic          active;
        logic [LW-1:0] cnt;
    } lp_t;

    lp_t q, d;

    always_comb begin
        d    = q;
        done = q.active && (q.cnt == LW'(LATCH_CYCLES - 1));
        if (start) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end else if (done) begin
            d = '0;
        end else if (q.active) begin
            d.cnt = q.cnt + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign active = q.active;
endmodule

// File: rtl/nonaligned_frame_serializer.sv
module nonaligned_frame_serializer
    import serializer_pkg::*;
#(
    parameter int FRAME_BITS   = 31,
    parameter int WORD_BITS    = 8,
    parameter int HALF_PERIOD  = 2,
    parameter int LATCH_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 free_run,
    input  logic                 rate_tick,
    input  logic [WORD_BITS-1:0] in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 ser_clk,
    output logic                 ser_data,
    output logic                 latch
);
    localparam int NW = $clog2(WORD_BITS + 1);

    typedef struct packed {
        fs_state_e            state;
        logic [WORD_BITS-1:0] shreg;
        logic [NW-1:0]        nbits;
    } ctl_t;

    ctl_t q, d;

    logic run, bit_done, frame_wrap, start_latch, latch_done;

    ser_bit_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sclk     (ser_clk),
        .bit_done (bit_done)
    );

    frame_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_count (
        .clk  (clk),
        .rst  (rst),
        .inc  (bit_done),
        .wrap (frame_wrap)
    );

    latch_pulse_gen #(.LATCH_CYCLES(LATCH_CYCLES)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .start  (start_latch),
        .active (latch),
        .done   (latch_done)
    );

    assign in_ready = (q.state == ST_SHIFT) && (q.nbits == '0);
    assign run      = (q.state == ST_SHIFT) && (q.nbits != '0);
    assign ser_data = q.shreg[WORD_BITS-1];

    always_comb begin
        d           = q;
        start_latch = 1'b0;
        unique case (q.state)
            ST_SHIFT: begin
                if (in_valid && in_ready) begin
                    d.shreg = in_data;
                    d.nbits = NW'(WORD_BITS);
                end else if (bit_done) begin
                    d.shreg = {q.shreg[WORD_BITS-2:0], 1'b0};
                    d.nbits = q.nbits - NW'(1);
                    if (frame_wrap) d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (free_run || rate_tick) begin
                    start_latch = 1'b1;
                    d.state     = ST_LATCH;
                end
            end
            ST_LATCH: begin
                if (latch_done) d.state = ST_SHIFT;
            end
            default: d.state = ST_SHIFT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= ST_SHIFT;
            q.shreg <= '0;
            q.nbits <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/serializer_checker.sv
module serializer_checker #(
    parameter int LATCH_CYCLES = 3
) (
    input logic clk,
    input logic rst,
    input logic free_run,
    input logic rate_tick,
    input logic in_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic latch
);
    localparam int CW = $clog2(LATCH_CYCLES + 2);

    logic [CW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst)        high_cnt <= '0;
        else if (latch) high_cnt <= high_cnt + CW'(1);
        else            high_cnt <= '0;
    end

    assert_latch_clk_low_R5: assert property (@(posedge clk) disable iff (rst)
        latch |-> !ser_clk);

    assert_ready_low_latch_R2: assert property (@(posedge clk) disable iff (rst)
        latch |-> !in_ready);

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    assert_data_edge_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> !ser_clk);

    assert_latch_go_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(latch) |-> $past(free_run || rate_tick));

    assert_latch_width_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(latch) |-> (high_cnt == CW'(LATCH_CYCLES)));

    assert_latch_bound_R8: assert property (@(posedge clk) disable iff (rst)
        high_cnt <= CW'(LATCH_CYCLES));
endmodule

bind nonaligned_frame_serializer serializer_checker #(.LATCH_CYCLES(LATCH_CYCLES)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .free_run  (free_run),
    .rate_tick (rate_tick),
    .in_ready  (in_ready),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .latch     (latch)
);

// File: tb/nonaligned_frame_serializer_test.sv
`timescale 1ns/1ps
module nonaligned_frame_serializer_test;
    localparam int FB   = 31;
    localparam int HP   = 2;
    localparam int LC   = 3;
    localparam int GAP  = 150;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic free_run = 1'b0;
    logic rate_tick = 1'b0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0;
    logic in_ready, ser_clk, ser_data, latch;

    nonaligned_frame_serializer #(
        .FRAME_BITS(FB), .WORD_BITS(8), .HALF_PERIOD(HP), .LATCH_CYCLES(LC)
    ) uut (
        .clk(clk), .rst(rst), .free_run(free_run), .rate_tick(rate_tick),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .ser_clk(ser_clk), .ser_data(ser_data), .latch(latch)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit cap_q[$];
    bit exp_q[$];
    int latch_total = 0;
    int wait_cnt = 0;
    int lw_cnt = 0;
    logic prev_sclk = 0, prev_latch = 0, prev_go = 0, prev_data = 0;
    logic tick_en = 0, man_tick = 0;
    int tick_ctr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // rate tick source
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick_ctr++;
            rate_tick = (tick_en && (tick_ctr % GAP == 0)) || man_tick;
        end
    end

    // behavioural reference monitor, compared on every clock
    always @(negedge clk) begin
        if (rst) begin
            cap_q.delete();
            exp_q.delete();
            prev_sclk = 0; prev_latch = 0; prev_go = 0; prev_data = 0;
            lw_cnt = 0; wait_cnt = 0;
        end else begin
            int pending;
            bit exp_ready;
            bit just_full;
            pending   = exp_q.size() - cap_q.size();
            exp_ready = (pending == 0) && !ser_clk && (cap_q.size() != FB) && !latch;
            check(in_ready == exp_ready, "R2", "in_ready", in_ready, exp_ready);
            if (ser_clk && prev_sclk)
                check(ser_data == prev_data, "R3", "data held while clock high",
                      ser_data, prev_data);
            just_full = 0;
            if (ser_clk && !prev_sclk) begin
                check(cap_q.size() < FB && !latch, "R5", "clock rise past boundary",
                      cap_q.size(), FB - 1);
                cap_q.push_back(ser_data);
                if (cap_q.size() == FB) begin
                    wait_cnt = 0;
                    just_full = 1;
                end
            end
            if (cap_q.size() == FB && !just_full) wait_cnt++;
            if (latch && !prev_latch) begin
                int mism;
                latch_total++;
                check(cap_q.size() == FB, "R4", "bits in frame at latch", cap_q.size(), FB);
                check(prev_go == 1'b1, "R6", "latch without tick or free run", prev_go, 1);
                if (free_run)
                    check(wait_cnt == HP + 1, "R7", "free-run latch delay", wait_cnt, HP + 1);
                mism = 0;
                for (int i = 0; i < FB; i++) begin
                    bit e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
                    if (i < cap_q.size() && cap_q[i] != e) mism++;
                end
                check(mism == 0, "R4", "frame bit mismatches", mism, 0);
                cap_q.delete();
            end
            if (latch) lw_cnt++;
            if (!latch && prev_latch) begin
                check(lw_cnt == LC, "R8", "latch width", lw_cnt, LC);
                lw_cnt = 0;
            end
            prev_sclk  = ser_clk;
            prev_latch = latch;
            prev_data  = ser_data;
            prev_go    = free_run || rate_tick;
        end
    end

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 53 + 29) ^ (i << 3));
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (!(in_ready && exp_q.size() == cap_q.size()));
    endtask

    task automatic run_test();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(latch == 0 && ser_clk == 0 && ser_data == 0, "R1", "outputs after reset",
              {latch, ser_clk, ser_data}, 0);
        check(in_ready == 1, "R1", "ready after reset", in_ready, 1);

        // hold at a mid-byte boundary with no tick
        for (int i = 0; i < 4; i++) send_byte(pattern(i));
        repeat (600) @(negedge clk);
        check(cap_q.size() == FB, "R5", "bits shifted while held", cap_q.size(), FB);
        check(latch_total == 0, "R6", "latches without tick", latch_total, 0);
        check(ser_clk == 0, "R5", "clock idle while held", ser_clk, 0);
        man_tick = 1'b1;
        @(negedge clk);
        man_tick = 1'b0;
        repeat (LC + 4 * HP + 4) @(negedge clk);
        check(latch_total == 1, "R6", "latch after single tick", latch_total, 1);
        check(cap_q.size() == 1, "R8", "carried bit resumed", cap_q.size(), 1);

        // paced run to complete 31 bytes
        tick_en = 1'b1;
        for (int i = 4; i < 31; i++) send_byte(pattern(i));
        wait_idle();
        check(latch_total == 8, "R9", "latches after 31 bytes", latch_total, 8);
        check(cap_q.size() == 0, "R9", "bits left at realignment", cap_q.size(), 0);

        // free running
        tick_en  = 1'b0;
        free_run = 1'b1;
        for (int i = 31; i < 39; i++) send_byte(pattern(i));
        wait_idle();
        check(latch_total == 10, "R7", "free-run latch count", latch_total, 10);
        check(cap_q.size() == 2, "R7", "bits after two free-run frames", cap_q.size(), 2);

        // reset in the middle of a byte
        free_run = 1'b0;
        send_byte(8'hA5);
        repeat (10) @(negedge clk);
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(negedge clk);
        check(latch == 0 && ser_clk == 0 && ser_data == 0, "R1", "outputs in mid reset",
              {latch, ser_clk, ser_data}, 0);
        check(in_ready == 1, "R1", "ready in mid reset", in_ready, 1);
        @(posedge clk);
        #1 rst = 1'b0;

        // fresh frame count after reset, paced
        tick_en = 1'b1;
        for (int i = 40; i < 44; i++) send_byte(pattern(i));
        wait_idle();
        check(latch_total == 11, "R4", "latch count after reset", latch_total, 11);
        check(cap_q.size() == 1, "R4", "carry after fresh frame", cap_q.size(), 1);
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule